// File: doc/BRIEF.md
# GPIO Port Pin Multiplexer

This block sits between a 32-pin pad ring and the logic that wants to use those pads. Each pin can be handed to one of two peripheral functions, primary or alternate. It can also be taken over as a general-purpose pin. In general-purpose mode, a per-pin 2-bit selector picks the pad's output value. The choices are three peripheral source buses, called A, B and C, or a software data bit. The pad's drive enable then comes from a per-pin direction bit. Two more 2-bit selectors per pin choose what each pin presents on two peripheral-facing input buses.

The peripheral-facing input buses are the A-side and the B-side. Each can show the synchronized pad level, an interrupt status bit, or a constant 0 or 1. A per-pin pull-up request is driven straight from a register.

All settings live in 32-bit registers behind a simple bus with a write strobe and a read strobe. Read data comes out one cycle after the strobe. A read-only status word exposes the pad inputs after a two-flop synchronizer. Every pad-side and peripheral-side output is registered.

Top module: `gpio_pinmux`

## Requirements
- R1: While reset is held, and after it is released, every register is 0 and read data is 0. With all registers at 0, every pin follows its primary function's output and output enable, and the pull-up outputs are all 0.
- R2: A bus write updates the addressed register at the clock edge that samples the write strobe. A read returns the stored value on rdata one cycle after the read strobe.
- R2 (register offsets): direction is at 0x00. The data register is at 0x1C. The GPIO-ownership mask is at 0x20. The alternate-select mask is at 0x38. The pull-up mask is at 0x40.
- R2 (configuration word offsets): output-select low/high words are at 0x04/0x08. A-side input-select low/high words are at 0x0C/0x10. B-side input-select low/high words are at 0x14/0x18.
- R3: A read of any offset not listed in R2 or R9 returns 0. Writes to such offsets, and writes to the status offset 0x24, change no register.
- R4: A pin whose ownership bit is 0 drives the pad from the primary function's output and enable when its alternate-select bit is 0. It drives the pad from the alternate function's output and enable when that bit is 1.
- R5: A pin whose ownership bit is 1 drives the pad from its 2-bit output-select field. Code 00 selects source A, 01 selects source B, 10 selects source C and 11 selects the data register bit. Pin i's field sits at bits [2i+1:2i] of the low word for pins 0-15, and at bits [2(i-16)+1:2(i-16)] of the high word for pins 16-31.
- R6: A pin whose ownership bit is 1 drives its pad output enable from its direction bit.
- R7: Each pin has one 2-bit field for the A-side input bus and one for the B-side input bus, laid out like R5. Each field independently selects code 00 for the synchronized pad input, 01 for the interrupt status bit, 10 for constant 0 and 11 for constant 1.
- R8: The pull-up outputs equal the pull-up mask register bit for bit.
- R9: A read of offset 0x24 returns the pad inputs through a two-flop synchronizer. A pad change made just before one clock edge is reported by a read whose strobe is sampled two edges later.
- R10: The pad outputs and enables are registered. A change on a peripheral input appears on the pad one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pad pull-up requests |
| pri_out | input | 32 | Primary function output per pin |
| pri_oe | input | 32 | Primary function output enable per pin |
| alt_out | input | 32 | Alternate function output per pin |
| alt_oe | input | 32 | Alternate function output enable per pin |
| src_a | input | 32 | GPIO output source A per pin |
| src_b | input | 32 | GPIO output source B per pin |
| src_c | input | 32 | GPIO output source C per pin |
| irq_stat | input | 32 | Interrupt status per pin |
| pin_in_a | output | 32 | A-side peripheral input bus |
| pin_in_b | output | 32 | B-side peripheral input bus |

## Verification
The hardest situation to reach is a single port state in which all four codes of every selector are in use at once. In that state, a wrong field offset or a swapped low/high word shows up as a wrong bit on one particular pin. The stimulus writes repeating field patterns, so that pin i uses code i mod 4 and a neighbouring pin uses a different code. It then changes only the high word, which exposes the split between pins 0-15 and 16-31. The synchronizer latency is checked by changing the pad just before reading the status word twice in a row: the first read still shows the old level and the second shows the new one.

// File: rtl/gpmx_pkg.sv
package gpmx_pkg;

  // register byte offsets (decoded by software, so they are fixed)
  localparam int OFS_DIR    = 'h00;
  localparam int OFS_OSEL_L = 'h04;
  localparam int OFS_OSEL_H = 'h08;
  localparam int OFS_ISA_L  = 'h0C;
  localparam int OFS_ISA_H  = 'h10;
  localparam int OFS_ISB_L  = 'h14;
  localparam int OFS_ISB_H  = 'h18;
  localparam int OFS_DATA   = 'h1C;
  localparam int OFS_OWN    = 'h20;
  localparam int OFS_STAT   = 'h24;
  localparam int OFS_ALT    = 'h38;
  localparam int OFS_PULL   = 'h40;

  typedef enum logic [1:0] {
    OSEL_SRC_A = 2'b00,
    OSEL_SRC_B = 2'b01,
    OSEL_SRC_C = 2'b10,
    OSEL_DATA  = 2'b11
  } osel_e;

  typedef enum logic [1:0] {
    ISEL_PAD  = 2'b00,
    ISEL_IRQ  = 2'b01,
    ISEL_ZERO = 2'b10,
    ISEL_ONE  = 2'b11
  } isel_e;

  function automatic logic offset_known(input int a);
    case (a)
      OFS_DIR, OFS_OSEL_L, OFS_OSEL_H, OFS_ISA_L, OFS_ISA_H,
      OFS_ISB_L, OFS_ISB_H, OFS_DATA, OFS_OWN, OFS_STAT,
      OFS_ALT, OFS_PULL: return 1'b1;
      default:           return 1'b0;
    endcase
  endfunction

  function automatic logic pick_out(input logic [1:0] s, input logic a,
                                    input logic b, input logic c,
                                    input logic d);
    case (osel_e'(s))
      OSEL_SRC_A: return a;
      OSEL_SRC_B: return b;
      OSEL_SRC_C: return c;
      default:    return d;
    endcase
  endfunction

  function automatic logic pick_in(input logic [1:0] s, input logic pad,
                                   input logic irq);
    case (isel_e'(s))
      ISEL_PAD:  return pad;
      ISEL_IRQ:  return irq;
      ISEL_ZERO: return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/gpmx_sync.sv
module gpmx_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpmx_regs.sv
module gpmx_regs
  import gpmx_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  localparam int CFG_W = 2 * NPINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  pad_sync_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  data_o,
  output logic [NPINS-1:0]  own_o,
  output logic [NPINS-1:0]  alt_o,
  output logic [NPINS-1:0]  pull_o,
  output logic [CFG_W-1:0]  osel_o,
  output logic [CFG_W-1:0]  isa_o,
  output logic [CFG_W-1:0]  isb_o
);

  logic [NPINS-1:0] dir_q, data_q, own_q, alt_q, pull_q;
  logic [CFG_W-1:0] osel_q, isa_q, isb_q;
  logic [NPINS-1:0] rd_mux;
  int               a_int;

  assign a_int = int'(addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      own_q  <= '0;
      alt_q  <= '0;
      pull_q <= '0;
      osel_q <= '0;
      isa_q  <= '0;
      isb_q  <= '0;
    end else if (wr_en_i) begin
      case (a_int)
        OFS_DIR:    dir_q                <= wdata_i;
        OFS_DATA:   data_q               <= wdata_i;
        OFS_OWN:    own_q                <= wdata_i;
        OFS_ALT:    alt_q                <= wdata_i;
        OFS_PULL:   pull_q               <= wdata_i;
        OFS_OSEL_L: osel_q[NPINS-1:0]     <= wdata_i;
        OFS_OSEL_H: osel_q[CFG_W-1:NPINS] <= wdata_i;
        OFS_ISA_L:  isa_q[NPINS-1:0]      <= wdata_i;
        OFS_ISA_H:  isa_q[CFG_W-1:NPINS]  <= wdata_i;
        OFS_ISB_L:  isb_q[NPINS-1:0]      <= wdata_i;
        OFS_ISB_H:  isb_q[CFG_W-1:NPINS]  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (a_int)
      OFS_DIR:    rd_mux = dir_q;
      OFS_DATA:   rd_mux = data_q;
      OFS_OWN:    rd_mux = own_q;
      OFS_ALT:    rd_mux = alt_q;
      OFS_PULL:   rd_mux = pull_q;
      OFS_STAT:   rd_mux = pad_sync_i;
      OFS_OSEL_L: rd_mux = osel_q[NPINS-1:0];
      OFS_OSEL_H: rd_mux = osel_q[CFG_W-1:NPINS];
      OFS_ISA_L:  rd_mux = isa_q[NPINS-1:0];
      OFS_ISA_H:  rd_mux = isa_q[CFG_W-1:NPINS];
      OFS_ISB_L:  rd_mux = isb_q[NPINS-1:0];
      OFS_ISB_H:  rd_mux = isb_q[CFG_W-1:NPINS];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;
  assign own_o  = own_q;
  assign alt_o  = alt_q;
  assign pull_o = pull_q;
  assign osel_o = osel_q;
  assign isa_o  = isa_q;
  assign isb_o  = isb_q;

  // R1: reset clears every register and the read port
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && own_q == '0 && alt_q == '0 && pull_q == '0 &&
             osel_q == '0 && isa_q == '0 && isb_q == '0 && rdata_o == '0));

  // R2: a write to the direction offset lands at the next edge
  p_write_dir_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && a_int == OFS_DIR) |=> dir_q == $past(wdata_i));

  // R2: a write to the ownership offset lands at the next edge
  p_write_own_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && a_int == OFS_OWN) |=> own_q == $past(wdata_i));

  // R3: unmapped offsets read as zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !offset_known(a_int)) |=> rdata_o == '0);

  // R3: unmapped writes leave the pull-up mask alone
  p_unmapped_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !offset_known(a_int)) |=> $stable(pull_q));

endmodule

// File: rtl/gpmx_route.sv
module gpmx_route
  import gpmx_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int CFG_W = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] own_i,
  input  logic [NPINS-1:0] alt_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] data_i,
  input  logic [CFG_W-1:0] osel_i,
  input  logic [CFG_W-1:0] isa_i,
  input  logic [CFG_W-1:0] isb_i,
  input  logic [NPINS-1:0] pad_sync_i,
  input  logic [NPINS-1:0] irq_i,
  input  logic [NPINS-1:0] pri_out_i,
  input  logic [NPINS-1:0] pri_oe_i,
  input  logic [NPINS-1:0] alt_out_i,
  input  logic [NPINS-1:0] alt_oe_i,
  input  logic [NPINS-1:0] src_a_i,
  input  logic [NPINS-1:0] src_b_i,
  input  logic [NPINS-1:0] src_c_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] in_a_o,
  output logic [NPINS-1:0] in_b_o
);

  logic [NPINS-1:0] out_d, oe_d, ina_d, inb_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic gpio_val;
    logic per_val;
    logic per_oe;

    assign gpio_val = pick_out(osel_i[2*i +: 2], src_a_i[i], src_b_i[i],
                               src_c_i[i], data_i[i]);
    assign per_val  = alt_i[i] ? alt_out_i[i] : pri_out_i[i];
    assign per_oe   = alt_i[i] ? alt_oe_i[i]  : pri_oe_i[i];

    assign out_d[i] = own_i[i] ? gpio_val : per_val;
    assign oe_d[i]  = own_i[i] ? dir_i[i] : per_oe;
    assign ina_d[i] = pick_in(isa_i[2*i +: 2], pad_sync_i[i], irq_i[i]);
    assign inb_d[i] = pick_in(isb_i[2*i +: 2], pad_sync_i[i], irq_i[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_o <= '0;
      pad_oe_o  <= '0;
      in_a_o    <= '0;
      in_b_o    <= '0;
    end else begin
      pad_out_o <= out_d;
      pad_oe_o  <= oe_d;
      in_a_o    <= ina_d;
      in_b_o    <= inb_d;
    end
  end

  // R4: a port fully on its primary function follows it one edge later
  p_primary_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (own_i == '0 && alt_i == '0) |=>
      (pad_out_o == $past(pri_out_i) && pad_oe_o == $past(pri_oe_i)));

  // R4: a port fully on its alternate function follows it
  p_alternate_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (own_i == '0 && alt_i == '1) |=> pad_out_o == $past(alt_out_i));

  // R6: in GPIO ownership the enable tracks the direction register
  p_gpio_oe_r6: assert property (@(posedge clk) disable iff (rst)
    (own_i == '1) |=> pad_oe_o == $past(dir_i));

  // R7: all A-side fields at code 11 give an all-ones bus
  p_force_one_r7: assert property (@(posedge clk) disable iff (rst)
    (isa_i == '1) |=> in_a_o == '1);

  // R7: all B-side fields at code 10 give an all-zero bus
  p_force_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (isb_i == {NPINS{2'b10}}) |=> in_b_o == '0);

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpmx_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  input  logic [NPINS-1:0]  pri_out,
  input  logic [NPINS-1:0]  pri_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  input  logic [NPINS-1:0]  src_a,
  input  logic [NPINS-1:0]  src_b,
  input  logic [NPINS-1:0]  src_c,
  input  logic [NPINS-1:0]  irq_stat,
  output logic [NPINS-1:0]  pin_in_a,
  output logic [NPINS-1:0]  pin_in_b
);

  localparam int CFG_W = 2 * NPINS;

  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] dir_r, data_r, own_r, alt_r, pull_r;
  logic [CFG_W-1:0] osel_r, isa_r, isb_r;

  gpmx_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pad_in),
    .sync_o  (pad_sync)
  );

  gpmx_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .pad_sync_i (pad_sync),
    .rdata_o    (rdata),
    .dir_o      (dir_r),
    .data_o     (data_r),
    .own_o      (own_r),
    .alt_o      (alt_r),
    .pull_o     (pull_r),
    .osel_o     (osel_r),
    .isa_o      (isa_r),
    .isb_o      (isb_r)
  );

  gpmx_route #(.NPINS(NPINS)) u_route (
    .clk        (clk),
    .rst        (rst),
    .own_i      (own_r),
    .alt_i      (alt_r),
    .dir_i      (dir_r),
    .data_i     (data_r),
    .osel_i     (osel_r),
    .isa_i      (isa_r),
    .isb_i      (isb_r),
    .pad_sync_i (pad_sync),
    .irq_i      (irq_stat),
    .pri_out_i  (pri_out),
    .pri_oe_i   (pri_oe),
    .alt_out_i  (alt_out),
    .alt_oe_i   (alt_oe),
    .src_a_i    (src_a),
    .src_b_i    (src_b),
    .src_c_i    (src_c),
    .pad_out_o  (pad_out),
    .pad_oe_o   (pad_oe),
    .in_a_o     (pin_in_a),
    .in_b_o     (pin_in_b)
  );

  assign pad_pu = pull_r;

  // R8: pull-up requests always mirror the mask after reset
  p_pull_mirror_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(addr) == OFS_PULL) |=> pad_pu == $past(wdata));

endmodule

// File: tb/test_gpio_pinmux.sv
module test_gpio_pinmux;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_out, pad_oe, pad_pu, pin_in_a, pin_in_b;
  logic [31:0] pad_in = '0, pri_out = '0, pri_oe = '0, alt_out = '0;
  logic [31:0] alt_oe = '0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0, irq_stat = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  gpio_pinmux i_gpio_pinmux (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pri_out(pri_out), .pri_oe(pri_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .src_a(src_a), .src_b(src_b),
    .src_c(src_c), .irq_stat(irq_stat), .pin_in_a(pin_in_a),
    .pin_in_b(pin_in_b)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_out(input logic [31:0] lo,
      input logic [31:0] hi, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] s;
      s = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      r[i] = (s == 2'd0) ? a[i] : (s == 2'd1) ? b[i] : (s == 2'd2) ? c[i] : d[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_in(input logic [31:0] lo,
      input logic [31:0] hi, input logic [31:0] pad, input logic [31:0] irq);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] s;
      s = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      r[i] = (s == 2'd0) ? pad[i] : (s == 2'd1) ? irq[i] : (s == 2'd2) ? 1'b0 : 1'b1;
    end
    return r;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pad_out in reset", pad_out, 32'h0);
    rst = 1'b0;
    settle(2);
    chk("R1 primary out after reset", pad_out, pri_out);
    chk("R1 primary oe after reset", pad_oe, pri_oe);
    chk("R1 pull-ups after reset", pad_pu, 32'h0);
    rd(8'h20, d); chk("R1 ownership reads 0", d, 32'h0);
    rd(8'h04, d); chk("R1 output select reads 0", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [7:0] offs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                              8'h18, 8'h1C, 8'h20, 8'h38, 8'h40};
    logic [31:0] d;
    foreach (offs[k]) wr(offs[k], 32'hA5C3_0000 | {24'h0, offs[k]} | (k << 12));
    foreach (offs[k]) begin
      rd(offs[k], d);
      chk("R2 register readback", d, 32'hA5C3_0000 | {24'h0, offs[k]} | (k << 12));
    end
  endtask

  task automatic t_unmapped;
    logic [7:0] offs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                              8'h18, 8'h1C, 8'h20, 8'h38, 8'h40};
    logic [31:0] d;
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h2C, d); chk("R3 unmapped 0x2C reads 0", d, 32'h0);
    rd(8'h44, d); chk("R3 unmapped 0x44 reads 0", d, 32'h0);
    foreach (offs[k]) begin
      rd(offs[k], d);
      chk("R3 register kept after stray write", d,
          32'hA5C3_0000 | {24'h0, offs[k]} | (k << 12));
    end
  endtask

  task automatic t_periph;
    logic [31:0] own = 32'hFFFF_0000, alt = 32'h0000_FF00;
    logic [31:0] dir = 32'hF0F0_F0F0, dat = 32'h3C3C_3C3C;
    logic [31:0] old_exp;
    pri_out = 32'h1111_2222; pri_oe = 32'h3333_4444;
    alt_out = 32'h5555_6666; alt_oe = 32'h7777_8888;
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h00, dir); wr(8'h1C, dat);
    wr(8'h38, alt); wr(8'h20, own);
    settle(2);
    chk("R4 mixed-mode pad_out", pad_out,
        (own & dat) | (~own & alt & alt_out) | (~own & ~alt & pri_out));
    chk("R4 mixed-mode pad_oe", pad_oe,
        (own & dir) | (~own & alt & alt_oe) | (~own & ~alt & pri_oe));
    old_exp = (own & dat) | (~own & alt & alt_out) | (~own & ~alt & pri_out);
    pri_out = 32'h1111_22DD;
    #1;
    chk("R10 pad_out unchanged before edge", pad_out, old_exp);
    @(negedge clk);
    chk("R10 pad_out updated after one edge", pad_out,
        (own & dat) | (~own & alt & alt_out) | (~own & ~alt & pri_out));
  endtask

  task automatic t_gpio_out;
    src_a = 32'hAAAA_5555; src_b = 32'h0F0F_33CC; src_c = 32'h1234_5678;
    wr(8'h1C, 32'hCAFE_F00D);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h04, 32'hE4E4_E4E4); wr(8'h08, 32'hE4E4_E4E4);
    settle(2);
    chk("R5 mixed output codes", pad_out,
        exp_out(32'hE4E4_E4E4, 32'hE4E4_E4E4, src_a, src_b, src_c, 32'hCAFE_F00D));
    wr(8'h08, 32'h0000_0000);
    settle(2);
    chk("R5 high word selects source A", pad_out,
        exp_out(32'hE4E4_E4E4, 32'h0, src_a, src_b, src_c, 32'hCAFE_F00D));
    wr(8'h04, 32'hAAAA_AAAA);
    settle(2);
    chk("R5 low word selects source C", pad_out,
        exp_out(32'hAAAA_AAAA, 32'h0, src_a, src_b, src_c, 32'hCAFE_F00D));
  endtask

  task automatic t_dir;
    wr(8'h00, 32'h00FF_00F0);
    settle(2);
    chk("R6 oe follows direction", pad_oe, 32'h00FF_00F0);
    wr(8'h00, 32'h8000_0001);
    settle(2);
    chk("R6 oe follows new direction", pad_oe, 32'h8000_0001);
  endtask

  task automatic t_input;
    pad_in = 32'h5A5A_C3C3; irq_stat = 32'h0FF0_F00F;
    wr(8'h0C, 32'h1B1B_1B1B); wr(8'h10, 32'hE4E4_E4E4);
    wr(8'h14, 32'hE4E4_E4E4); wr(8'h18, 32'h1B1B_1B1B);
    settle(4);
    chk("R7 A-side mixed codes", pin_in_a,
        exp_in(32'h1B1B_1B1B, 32'hE4E4_E4E4, pad_in, irq_stat));
    chk("R7 B-side mixed codes", pin_in_b,
        exp_in(32'hE4E4_E4E4, 32'h1B1B_1B1B, pad_in, irq_stat));
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hAAAA_AAAA); wr(8'h18, 32'hAAAA_AAAA);
    settle(2);
    chk("R7 A-side forced one", pin_in_a, 32'hFFFF_FFFF);
    chk("R7 B-side forced zero", pin_in_b, 32'h0);
  endtask

  task automatic t_pullup;
    wr(8'h40, 32'h8001_0042);
    settle(1);
    chk("R8 pull-ups follow mask", pad_pu, 32'h8001_0042);
  endtask

  task automatic t_status;
    logic [31:0] d;
    pad_in = 32'h1357_2468;
    settle(4);
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd(8'h24, d); chk("R9 status still old level", d, 32'h1357_2468);
    rd(8'h24, d); chk("R9 status shows new level", d, 32'hDEAD_BEEF);
  endtask

  initial begin
    pri_out = 32'h1357_9BDF;
    pri_oe  = 32'h0F0F_0F0F;
    settle(3);
    t_reset();
    t_regs();
    t_unmapped();
    t_periph();
    t_gpio_out();
    t_dir();
    t_input();
    t_pullup();
    t_status();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule